// File: doc/BRIEF.md
# Packet FIFO Write Port with Automatic and Manual Commit

This block is the write side of a slave packet FIFO for one IN endpoint. An external master presents a data word on each rising edge of the interface clock with the write strobe high. The block stores each accepted word in one of several packet buffers and counts the words of the packet being built. When that count reaches a programmable length, the packet is committed on its own. The master can also close a shorter packet at any time with a packet-end strobe. A short packet may hold a single word or no words at all.

Both commit sources act on one word counter. A packet-end that arrives together with the write that completes an automatic packet is lost, and so is one that arrives on the edge right after it. Each such loss raises a one-cycle drop flag. Every commit is reported as a one-cycle pulse that carries the packet length, the buffer it occupies and whether it was size-triggered. The buffers fill in ring order. A read-side done pulse hands a buffer back. Full and empty flags summarise the ring, and a registered read port gives access to the stored words.

Top module: `pkt_wr_port`

## Requirements
- R1: A word written while the write strobe is high and the port is selected is stored at buffer address `buf*MAXLEN + index`, where index is its zero-based position in the packet. It is readable on `rd_data` one cycle after `rd_addr` is applied.
- R2: With automatic mode on, the write that brings the packet count to the programmed length L commits the packet. On the next cycle `commit_vld` pulses with `commit_len`=L and `commit_auto`=1, and the counter restarts at zero.
- R3: A packet-end with no pending spacing violation commits the words buffered so far as a short packet with `commit_auto`=0. A write in the same cycle is included in that packet, so a lone write plus packet-end gives length 1.
- R4: A packet-end while the counter is zero and no spacing violation is pending commits a packet of length 0.
- R5: If a packet-end arrives in the same cycle as the write that completes an automatic packet, only the automatic commit happens. `drop` pulses on the same output cycle as that commit.
- R6: A packet-end sampled on the edge immediately after an automatic commit is dropped and `drop` pulses. A packet-end one edge later is honoured.
- R7: Writes and packet-ends are ignored unless `ep_sel` equals the parameter `EP_ID`. An ignored cycle produces neither a commit nor a drop and does not advance the counter.
- R8: With automatic mode off, or with a programmed length of 0 or above MAXLEN, the commit length is MAXLEN and the commit is flagged with `commit_auto`=1.
- R9: After NBUF commits with no release, `full` goes high. While `full` is high, writes and packet-ends are ignored. A `rel_done` pulse frees one buffer and clears `full`.
- R10: `empty` is high exactly when no committed buffer is waiting for release, and `full` and `empty` are never high together.
- R11: `commit_buf` starts at 0 after reset and advances by one per commit, wrapping modulo NBUF.
- R12: After reset, `commit_vld`, `drop` and `full` are low and `empty` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Interface clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe |
| wr_data | input | DW | Write data |
| ep_sel | input | EPW | Endpoint FIFO address select |
| pkt_end | input | 1 | Packet-end strobe (manual commit) |
| auto_en | input | 1 | Automatic commit mode enable |
| auto_len | input | LW | Programmed automatic packet length |
| rel_done | input | 1 | Read side releases the oldest committed buffer |
| rd_addr | input | AW | Read address into buffer storage |
| commit_vld | output | 1 | One-cycle commit pulse |
| commit_len | output | LW | Length of the committed packet |
| commit_auto | output | 1 | 1 = size-triggered commit, 0 = packet-end commit |
| commit_buf | output | BW | Buffer index of the committed packet |
| drop | output | 1 | One-cycle pulse: a packet-end was discarded |
| full | output | 1 | All buffers committed and unreleased |
| empty | output | 1 | No committed buffer outstanding |
| rd_data | output | DW | Registered read data |

## Verification
The hardest case to reach is the one-edge window after an automatic commit. The stimulus has to complete a packet with a write and then assert the packet-end on exactly the next edge. Only the presence or absence of the following zero-length commit shows whether the window was honoured. The bench drives inputs cycle by cycle on the falling edge, so it places the packet-end on the completing edge, on the edge after it, and one edge later. It also fills all buffers with zero-length commits, then offers a write and a packet-end while full, and afterwards shows that the counter still starts from zero.

// File: rtl/pkt_wr_pkg.sv
package pkt_wr_pkg;

  typedef enum logic {
    CK_SHORT = 1'b0,
    CK_AUTO  = 1'b1
  } commit_kind_e;

  // Effective packet length: capacity when auto mode is off or the
  // programmed value is outside 1..maxlen.
  function automatic int eff_len(input bit en, input int alen, input int maxlen);
    if (!en || alen == 0 || alen > maxlen) return maxlen;
    return alen;
  endfunction

endpackage

// File: rtl/pkt_wr_ctrl.sv
module pkt_wr_ctrl #(
  parameter  int MAXLEN = 16,
  localparam int LW     = $clog2(MAXLEN + 1)
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr_ok,
  input  logic                          pe_ok,
  input  logic [LW-1:0]                 lim,
  output logic [LW-1:0]                 cnt,
  output logic                          commit,
  output pkt_wr_pkg::commit_kind_e      kind,
  output logic                          drop,
  output logic [LW-1:0]                 len
);
  import pkt_wr_pkg::*;

  logic [LW-1:0] cnt_q, nxt;
  logic          guard_q, hit;

  always_comb begin
    nxt    = cnt_q + LW'(wr_ok);
    hit    = wr_ok && (nxt == lim);
    commit = 1'b0;
    kind   = CK_SHORT;
    drop   = 1'b0;
    len    = nxt;
    if (hit) begin
      commit = 1'b1;
      kind   = CK_AUTO;
      drop   = pe_ok;
    end else if (pe_ok && guard_q) begin
      drop = 1'b1;
    end else if (pe_ok) begin
      commit = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q   <= '0;
      guard_q <= 1'b0;
    end else begin
      cnt_q   <= commit ? '0 : nxt;
      guard_q <= hit;
    end
  end

  assign cnt = cnt_q;

endmodule

// File: rtl/pkt_wr_ring.sv
module pkt_wr_ring #(
  parameter  int NBUF = 4,
  localparam int BW   = $clog2(NBUF),
  localparam int UW   = $clog2(NBUF + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          commit,
  input  logic          release_i,
  output logic [BW-1:0] wbuf,
  output logic          full,
  output logic          empty
);
  logic [UW-1:0] used_q, used_nxt;
  logic          rel_ok;

  always_comb begin
    rel_ok   = release_i && (used_q != '0);
    used_nxt = used_q + UW'(commit) - UW'(rel_ok);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      used_q <= '0;
      wbuf   <= '0;
      full   <= 1'b0;
      empty  <= 1'b1;
    end else begin
      used_q <= used_nxt;
      full   <= (used_nxt == UW'(NBUF));
      empty  <= (used_nxt == '0);
      if (commit)
        wbuf <= (wbuf == BW'(NBUF - 1)) ? '0 : wbuf + 1'b1;
    end
  end

endmodule

// File: rtl/pkt_wr_mem.sv
module pkt_wr_mem #(
  parameter  int DW    = 16,
  parameter  int DEPTH = 64,
  localparam int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end

endmodule

// File: rtl/pkt_wr_port.sv
module pkt_wr_port #(
  parameter  int DW     = 16,
  parameter  int MAXLEN = 16,
  parameter  int NBUF   = 4,
  parameter  int EPW    = 2,
  parameter  int EP_ID  = 2,
  localparam int LW     = $clog2(MAXLEN + 1),
  localparam int BW     = $clog2(NBUF),
  localparam int DEPTH  = NBUF * MAXLEN,
  localparam int AW     = $clog2(DEPTH)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           wr_en,
  input  logic [DW-1:0]  wr_data,
  input  logic [EPW-1:0] ep_sel,
  input  logic           pkt_end,
  input  logic           auto_en,
  input  logic [LW-1:0]  auto_len,
  input  logic           rel_done,
  input  logic [AW-1:0]  rd_addr,
  output logic           commit_vld,
  output logic [LW-1:0]  commit_len,
  output logic           commit_auto,
  output logic [BW-1:0]  commit_buf,
  output logic           drop,
  output logic           full,
  output logic           empty,
  output logic [DW-1:0]  rd_data
);
  import pkt_wr_pkg::*;

  logic          sel_hit, wr_ok, pe_ok;
  logic [LW-1:0] lim, cnt, len_c;
  logic          commit_c, drop_c;
  commit_kind_e  kind_c;
  logic [BW-1:0] wbuf;
  logic [AW-1:0] waddr;

  assign sel_hit = (ep_sel == EPW'(EP_ID));
  assign wr_ok   = wr_en && sel_hit && !full;
  assign pe_ok   = pkt_end && sel_hit && !full;
  assign lim     = LW'(eff_len(auto_en, int'(auto_len), MAXLEN));
  assign waddr   = AW'(wbuf) * AW'(MAXLEN) + AW'(cnt);

  pkt_wr_ctrl #(.MAXLEN(MAXLEN)) u_ctrl (
    .clk    (clk),
    .rst    (rst),
    .wr_ok  (wr_ok),
    .pe_ok  (pe_ok),
    .lim    (lim),
    .cnt    (cnt),
    .commit (commit_c),
    .kind   (kind_c),
    .drop   (drop_c),
    .len    (len_c)
  );

  pkt_wr_ring #(.NBUF(NBUF)) u_ring (
    .clk       (clk),
    .rst       (rst),
    .commit    (commit_c),
    .release_i (rel_done),
    .wbuf      (wbuf),
    .full      (full),
    .empty     (empty)
  );

  pkt_wr_mem #(.DW(DW), .DEPTH(DEPTH)) u_mem (
    .clk   (clk),
    .we    (wr_ok),
    .waddr (waddr),
    .wdata (wr_data),
    .raddr (rd_addr),
    .rdata (rd_data)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      commit_vld  <= 1'b0;
      commit_len  <= '0;
      commit_auto <= 1'b0;
      commit_buf  <= '0;
      drop        <= 1'b0;
    end else begin
      commit_vld  <= commit_c;
      commit_len  <= len_c;
      commit_auto <= (kind_c == CK_AUTO);
      commit_buf  <= wbuf;
      drop        <= drop_c;
    end
  end

endmodule

// File: rtl/pkt_wr_port_chk.sv
module pkt_wr_port_chk #(
  parameter  int MAXLEN = 16,
  parameter  int EPW    = 2,
  parameter  int EP_ID  = 2,
  localparam int LW     = $clog2(MAXLEN + 1)
) (
  input logic           clk,
  input logic           rst,
  input logic [EPW-1:0] ep_sel,
  input logic           pkt_end,
  input logic           auto_en,
  input logic [LW-1:0]  auto_len,
  input logic           rel_done,
  input logic           commit_vld,
  input logic [LW-1:0]  commit_len,
  input logic           commit_auto,
  input logic           drop,
  input logic           full,
  input logic           empty
);
  logic [LW-1:0] lim_chk;
  assign lim_chk = (!auto_en || auto_len == '0 || auto_len > LW'(MAXLEN))
                   ? LW'(MAXLEN) : auto_len;

  p_len_max_r2: assert property (@(posedge clk) disable iff (rst)
    commit_vld |-> commit_len <= LW'(MAXLEN));

  p_auto_len_r8: assert property (@(posedge clk) disable iff (rst)
    commit_vld && commit_auto |-> commit_len == $past(lim_chk));

  p_drop_src_r5: assert property (@(posedge clk) disable iff (rst)
    drop |-> $past(pkt_end));

  p_guard_r6: assert property (@(posedge clk) disable iff (rst)
    commit_vld && commit_auto && pkt_end && ep_sel == EPW'(EP_ID) && !full |=> drop);

  p_addr_r7: assert property (@(posedge clk) disable iff (rst)
    ep_sel != EPW'(EP_ID) |=> !commit_vld && !drop);

  p_full_hold_r9: assert property (@(posedge clk) disable iff (rst)
    full && !rel_done |=> full);

  p_no_commit_full_r9: assert property (@(posedge clk) disable iff (rst)
    full |=> !commit_vld);

  p_flags_r10: assert property (@(posedge clk) disable iff (rst)
    !(full && empty));

endmodule

bind pkt_wr_port pkt_wr_port_chk #(.MAXLEN(MAXLEN), .EPW(EPW), .EP_ID(EP_ID)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .ep_sel      (ep_sel),
  .pkt_end     (pkt_end),
  .auto_en     (auto_en),
  .auto_len    (auto_len),
  .rel_done    (rel_done),
  .commit_vld  (commit_vld),
  .commit_len  (commit_len),
  .commit_auto (commit_auto),
  .drop        (drop),
  .full        (full),
  .empty       (empty)
);

// File: tb/test_pkt_wr_port.sv
module test_pkt_wr_port;
  localparam int DW     = 16;
  localparam int MAXLEN = 16;
  localparam int NBUF   = 4;
  localparam int EPW    = 2;
  localparam int EP_ID  = 2;
  localparam int LW     = $clog2(MAXLEN + 1);
  localparam int BW     = $clog2(NBUF);
  localparam int AW     = $clog2(NBUF * MAXLEN);

  logic           clk = 1'b0;
  logic           rst = 1'b1;
  logic           wr_en = 1'b0;
  logic [DW-1:0]  wr_data = '0;
  logic [EPW-1:0] ep_sel = EPW'(EP_ID);
  logic           pkt_end = 1'b0;
  logic           auto_en = 1'b1;
  logic [LW-1:0]  auto_len = LW'(4);
  logic           rel_done = 1'b0;
  logic [AW-1:0]  rd_addr = '0;
  logic           commit_vld, commit_auto, drop, full, empty;
  logic [LW-1:0]  commit_len;
  logic [BW-1:0]  commit_buf;
  logic [DW-1:0]  rd_data;

  pkt_wr_port #(.DW(DW), .MAXLEN(MAXLEN), .NBUF(NBUF), .EPW(EPW), .EP_ID(EP_ID)) i_pkt_wr_port (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(wr_data), .ep_sel(ep_sel),
    .pkt_end(pkt_end), .auto_en(auto_en), .auto_len(auto_len), .rel_done(rel_done),
    .rd_addr(rd_addr), .commit_vld(commit_vld), .commit_len(commit_len),
    .commit_auto(commit_auto), .commit_buf(commit_buf), .drop(drop),
    .full(full), .empty(empty), .rd_data(rd_data)
  );

  always #10 clk = ~clk;

  typedef struct {
    bit    is_drop;
    int    len;
    bit    auto_k;
    int    buf_i;
    string req;
  } exp_t;

  exp_t q[$];
  int   checks = 0;
  int   fails  = 0;
  int   nbuf   = 0;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic exp_commit(input int len, input bit a, input string req);
    q.push_back('{is_drop: 1'b0, len: len, auto_k: a, buf_i: nbuf, req: req});
    nbuf = (nbuf + 1) % NBUF;
  endtask

  task automatic exp_drop(input string req);
    q.push_back('{is_drop: 1'b1, len: 0, auto_k: 1'b0, buf_i: 0, req: req});
  endtask

  task automatic step(input bit we, input int d, input bit pe,
                      input int sel = EP_ID, input bit rel = 1'b0);
    @(negedge clk);
    wr_en    = we;
    wr_data  = DW'(d);
    pkt_end  = pe;
    ep_sel   = EPW'(sel);
    rel_done = rel;
  endtask

  task automatic idle();
    step(1'b0, 0, 1'b0);
  endtask

  task automatic release_one();
    step(1'b0, 0, 1'b0, EP_ID, 1'b1);
  endtask

  task automatic wr_n(input int n, input int base);
    for (int i = 0; i < n; i++) step(1'b1, base + i, 1'b0);
  endtask

  task automatic summary();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
  endtask

  // Monitor: pops the scoreboard as results appear
  initial begin
    forever begin
      @(negedge clk);
      if (!rst) begin
        if (commit_vld) begin
          if (q.size() == 0 || q[0].is_drop) begin
            check("R2", "unexpected commit_vld", 1, 0);
            if (q.size() != 0) void'(q.pop_front());
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "commit_len", int'(commit_len), e.len);
            check(e.req, "commit_auto", int'(commit_auto), int'(e.auto_k));
            check("R11", "commit_buf", int'(commit_buf), e.buf_i);
          end
        end
        if (drop) begin
          if (q.size() == 0 || !q[0].is_drop) begin
            check("R5", "unexpected drop", 1, 0);
            if (q.size() != 0) void'(q.pop_front());
          end else begin
            exp_t e;
            e = q.pop_front();
            check(e.req, "drop", 1, 1);
          end
        end
      end
    end
  end

  // Watchdog
  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL R0 watchdog actual=timeout expected=completion");
    summary();
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    check("R12", "commit_vld", int'(commit_vld), 0);
    check("R12", "drop", int'(drop), 0);
    check("R12", "full", int'(full), 0);
    check("R12", "empty", int'(empty), 1);
    rst = 1'b0;
    idle();

    // R2: auto commit at programmed length 4
    exp_commit(4, 1'b1, "R2");
    wr_n(4, 100);
    idle();
    idle();
    check("R10", "empty after commit", int'(empty), 0);
    release_one();
    idle();
    idle();
    check("R10", "empty after release", int'(empty), 1);
    // R1: stored word readable (buffer 0, index 2)
    rd_addr = AW'(2);
    idle();
    check("R1", "rd_data", int'(rd_data), 102);

    // R3: short packet including same-cycle write
    exp_commit(3, 1'b0, "R3");
    wr_n(2, 200);
    step(1'b1, 202, 1'b1);
    idle();
    release_one();
    rd_addr = AW'(1 * MAXLEN + 2);
    idle();
    check("R1", "rd_data short pkt", int'(rd_data), 202);

    // R3: lone write with packet-end gives length 1
    exp_commit(1, 1'b0, "R3");
    step(1'b1, 300, 1'b1);
    idle();
    release_one();

    // R4: zero-length commit
    exp_commit(0, 1'b0, "R4");
    step(1'b0, 0, 1'b1);
    idle();
    release_one();

    // R5: packet-end together with completing write
    exp_commit(4, 1'b1, "R5");
    exp_drop("R5");
    wr_n(3, 400);
    step(1'b1, 403, 1'b1);
    idle();
    release_one();

    // R6: packet-end one edge after auto commit is dropped, next edge honoured
    exp_commit(4, 1'b1, "R6");
    exp_drop("R6");
    exp_commit(0, 1'b0, "R6");
    wr_n(4, 500);
    step(1'b0, 0, 1'b1);
    step(1'b0, 0, 1'b1);
    idle();
    release_one();
    release_one();

    // R7: other endpoint address ignored
    for (int i = 0; i < 5; i++) step(1'b1, 600 + i, 1'b1, 0);
    idle();
    idle();
    check("R7", "no commit after foreign address", q.size(), 0);
    exp_commit(4, 1'b1, "R7");
    wr_n(4, 700);
    idle();
    release_one();

    // R8: auto off -> capacity
    auto_en = 1'b0;
    exp_commit(MAXLEN, 1'b1, "R8");
    wr_n(MAXLEN, 800);
    idle();
    release_one();
    // R8: programmed length 0 -> capacity
    auto_en  = 1'b1;
    auto_len = '0;
    exp_commit(MAXLEN, 1'b1, "R8");
    wr_n(MAXLEN, 900);
    idle();
    release_one();
    // R8: programmed length beyond capacity
    auto_len = LW'(20);
    exp_commit(MAXLEN, 1'b1, "R8");
    wr_n(MAXLEN, 1000);
    idle();
    release_one();
    auto_len = LW'(4);
    idle();

    // R9: fill every buffer, then blocked write/packet-end
    for (int i = 0; i < NBUF; i++) begin
      exp_commit(0, 1'b0, "R9");
      step(1'b0, 0, 1'b1);
    end
    idle();
    idle();
    check("R9", "full after NBUF commits", int'(full), 1);
    check("R10", "empty while full", int'(empty), 0);
    step(1'b1, 1100, 1'b1);
    idle();
    idle();
    check("R9", "full held", int'(full), 1);
    release_one();
    idle();
    idle();
    check("R9", "full cleared by release", int'(full), 0);
    exp_commit(4, 1'b1, "R9");
    wr_n(4, 1200);
    idle();
    for (int i = 0; i < NBUF; i++) release_one();
    idle();
    idle();
    check("R10", "empty after all released", int'(empty), 1);

    repeat (4) idle();
    check("R2", "scoreboard drained", q.size(), 0);
    summary();
    $finish;
  end

endmodule